// File: doc/BRIEF.md
# Register program command sequencer

This block runs a list of commands that sits in system memory. After a one-cycle start pulse it reads 32-bit words one after another from a programmable byte address, using a simple request/valid read port. The top four bits of each first word select the operation. The other 28 bits are operands.

The operations are:
- Pulse strobes that copy register sections from shadow storage into working registers.
- Pulse strobes that set or clear event signals.
- Stall on an event condition. An external evaluator resolves the condition from a mask and two mode bits. The stall has an optional timeout that counts bus clocks and/or vertical-sync pulses.
- A late-check form of the stall, which reports when the condition already held on arrival.
- Skip over a number of trailing payload words without interpreting them.
- End the task.

A timeout ends the task, sets a timeout status and, if enabled, raises an interrupt. An unknown operation code also ends the task and sets an error status.

The sequencer is controlled by one state machine with these states:
- ST_IDLE: no task running.
- ST_FETCH: a command word is being read.
- ST_EXEC: the word is decoded for one cycle.
- ST_WAIT: blocked on the condition.
- ST_SKIP: payload words are being read and discarded.

The transitions are:
- ST_IDLE → ST_FETCH on start.
- ST_FETCH → ST_EXEC when the word arrives.
- ST_EXEC → ST_IDLE on end-of-task or an unknown code.
- ST_EXEC → ST_WAIT on a stall whose condition is false.
- ST_EXEC → ST_SKIP on a skip with a nonzero count.
- ST_EXEC → ST_FETCH in every other case.
- ST_WAIT → ST_FETCH when the condition is met.
- ST_WAIT → ST_IDLE when the timeout expires.
- ST_SKIP → ST_FETCH after the last payload word.

Top module: `regprog_seq`

## Requirements
- R1: After reset, busy, mem_req, wait_active, every strobe and every status output are low.
- R2: The start pulse is accepted only while idle. It makes the first read go to start_addr, and each later read goes 4 bytes above the previous one. A start pulse while busy changes neither the address nor the flow.
- R3: Bits 31..28 of a first word hold the code. Code 0110 reads the number of extra words given in bits 7..0, discards them unexecuted, and then reads the next command.
- R4: Code 0010 drives upload_stb with bits NSEC-1..0 for exactly one cycle.
- R5: Code 0100 drives sig_set with bits NSIG-1..0 for one cycle. Code 0000 drives sig_clr with bits NSIG-1..0. When code 0000 has all operand bits zero, it does nothing and execution continues with the next word.
- R6: Code 0001 stalls with wait_active high. It presents bits 25..0 on wait_sel, bit 27 (1 = any event, 0 = all events) on wait_or and bit 26 (wait for false) on wait_inv. It continues once cond_met is high and leaves all status unchanged.
- R7: Code 0011 sets st_late and continues at once if cond_met is high when it is decoded. Otherwise it stalls like code 0001 and does not set st_late.
- R8: A stall counts a tick on each clock when tmo_count_clk is set, and on each cycle that vsync is high when tmo_count_vsync is set. With clock counting and limit L, wait_active stays high for L+2 cycles. The stall then ends the task: st_timeout is set, busy drops, and no later command runs.
- R9: irq goes high on a timeout only when irq_en is set. It stays high until the next accepted start.
- R10: A tmo_limit of zero never times out.
- R11: Code 0101 ends the task. Busy drops and no later word is read.
- R12: Codes 0111 to 1111 set st_error and end the task.
- R13: An accepted start clears st_timeout, st_late, st_error and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle task start pulse |
| start_addr | input | AW | Byte address of the first command word |
| tmo_limit | input | TW | Timeout tick limit; zero disables the timeout |
| tmo_count_clk | input | 1 | Count bus clocks as timeout ticks |
| tmo_count_vsync | input | 1 | Count vsync cycles as timeout ticks |
| vsync | input | 1 | Vertical sync pulse |
| irq_en | input | 1 | Interrupt enable for timeout |
| mem_req | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | AW | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| wait_active | output | 1 | Wait condition is being evaluated |
| wait_sel | output | 26 | Event select mask |
| wait_or | output | 1 | Combine events with OR (1) or AND (0) |
| wait_inv | output | 1 | Wait for the combined condition to be false |
| cond_met | input | 1 | Condition result from the event evaluator |
| upload_stb | output | NSEC | Section upload strobes |
| sig_set | output | NSIG | Signal set strobes |
| sig_clr | output | NSIG | Signal clear strobes |
| busy | output | 1 | Task running |
| st_timeout | output | 1 | Sticky timeout status |
| st_late | output | 1 | Sticky late-condition status |
| st_error | output | 1 | Sticky undefined-code status |
| irq | output | 1 | Timeout interrupt |

## Verification
The bench builds the block with TW = 8 and keeps AW = 32, NSEC = 8, NSIG = 8 and SKIP_W = 8 at their defaults. All eight upload and signal lanes are therefore visible, and skip counts up to 255 are possible. The narrow timer keeps small tick limits such as 2, 3 and 4 cheap to reach. With those limits, the exact L+2 stall length, vsync-only counting and the unbounded zero limit can each be checked within a few hundred cycles.

// File: rtl/regprog_pkg.sv
package regprog_pkg;

    localparam logic [3:0] OPC_CLR    = 4'h0;
    localparam logic [3:0] OPC_PAUSE  = 4'h1;
    localparam logic [3:0] OPC_UPLOAD = 4'h2;
    localparam logic [3:0] OPC_LATE   = 4'h3;
    localparam logic [3:0] OPC_SET    = 4'h4;
    localparam logic [3:0] OPC_STOP   = 4'h5;
    localparam logic [3:0] OPC_SKIP   = 4'h6;

    localparam int EVT_W   = 26;
    localparam int BIT_OR  = 27;
    localparam int BIT_INV = 26;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_WAIT,
        ST_SKIP
    } seq_state_e;

    typedef struct packed {
        logic clr;
        logic pause;
        logic upload;
        logic late;
        logic set;
        logic stop;
        logic skip;
        logic bad;
    } dec_t;

endpackage

// File: rtl/regprog_decode.sv
module regprog_decode import regprog_pkg::*; (
    input  logic [3:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec = '0;
        unique case (opcode)
            OPC_CLR:    dec.clr    = 1'b1;
            OPC_PAUSE:  dec.pause  = 1'b1;
            OPC_UPLOAD: dec.upload = 1'b1;
            OPC_LATE:   dec.late   = 1'b1;
            OPC_SET:    dec.set    = 1'b1;
            OPC_STOP:   dec.stop   = 1'b1;
            OPC_SKIP:   dec.skip   = 1'b1;
            default:    dec.bad    = 1'b1;
        endcase
    end
endmodule

// File: rtl/regprog_fetch.sv
module regprog_fetch #(
    parameter int AW = 32
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          want,
    output logic          got,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= load_addr;
        else if (want && mem_rvalid)
            addr_q <= addr_q + STEP;
    end

    assign got      = want && mem_rvalid;
    assign mem_req  = want;
    assign mem_addr = addr_q;
endmodule

// File: rtl/regprog_timer.sv
module regprog_timer #(
    parameter int TW = 16
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          count_clk,
    input  logic          count_vsync,
    input  logic          vsync,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;
    logic          tick;

    assign tick = count_clk || (count_vsync && vsync);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && tick && (cnt_q != limit))
            cnt_q <= cnt_q + TW'(1);
    end

    assign expired = run && (limit != '0) && (cnt_q == limit);
endmodule

// File: rtl/regprog_seq.sv
module regprog_seq import regprog_pkg::*; #(
    parameter int AW     = 32,
    parameter int TW     = 16,
    parameter int NSEC   = 8,
    parameter int NSIG   = 8,
    parameter int SKIP_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [TW-1:0]    tmo_limit,
    input  logic             tmo_count_clk,
    input  logic             tmo_count_vsync,
    input  logic             vsync,
    input  logic             irq_en,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             wait_active,
    output logic [EVT_W-1:0] wait_sel,
    output logic             wait_or,
    output logic             wait_inv,
    input  logic             cond_met,
    output logic [NSEC-1:0]  upload_stb,
    output logic [NSIG-1:0]  sig_set,
    output logic [NSIG-1:0]  sig_clr,
    output logic             busy,
    output logic             st_timeout,
    output logic             st_late,
    output logic             st_error,
    output logic             irq
);
    seq_state_e        state_q, state_d;
    dec_t              dec;
    logic [31:0]       cmd_q;
    logic [SKIP_W-1:0] skip_left_q;
    logic [SKIP_W-1:0] skip_len;
    logic              got, want, launch, in_exec, expired;
    logic              tmo_q, late_q, err_q, irq_q;

    assign in_exec  = (state_q == ST_EXEC);
    assign launch   = (state_q == ST_IDLE) && start;
    assign want     = (state_q == ST_FETCH) || (state_q == ST_SKIP);
    assign skip_len = cmd_q[SKIP_W-1:0];

    regprog_decode u_decode (
        .opcode (cmd_q[31:28]),
        .dec    (dec)
    );

    regprog_fetch #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .load_addr  (start_addr),
        .want       (want),
        .got        (got),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid)
    );

    regprog_timer #(.TW(TW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (in_exec),
        .run         (state_q == ST_WAIT),
        .count_clk   (tmo_count_clk),
        .count_vsync (tmo_count_vsync),
        .vsync       (vsync),
        .limit       (tmo_limit),
        .expired     (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: if (got) state_d = ST_EXEC;
            ST_EXEC: begin
                if (dec.bad || dec.stop)
                    state_d = ST_IDLE;
                else if (dec.pause || dec.late)
                    state_d = cond_met ? ST_FETCH : ST_WAIT;
                else if (dec.skip && (skip_len != '0))
                    state_d = ST_SKIP;
                else
                    state_d = ST_FETCH;
            end
            ST_WAIT: begin
                if (cond_met)
                    state_d = ST_FETCH;
                else if (expired)
                    state_d = ST_IDLE;
            end
            ST_SKIP: if (got && (skip_left_q == SKIP_W'(1))) state_d = ST_FETCH;
            default: state_d = ST_IDLE;
        endcase
    end

    // command word, skip counter and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            skip_left_q <= '0;
            tmo_q       <= 1'b0;
            late_q      <= 1'b0;
            err_q       <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            if (launch) begin
                tmo_q  <= 1'b0;
                late_q <= 1'b0;
                err_q  <= 1'b0;
                irq_q  <= 1'b0;
            end
            if ((state_q == ST_FETCH) && got)
                cmd_q <= mem_rdata;
            if (in_exec && dec.skip)
                skip_left_q <= skip_len;
            else if ((state_q == ST_SKIP) && got)
                skip_left_q <= skip_left_q - SKIP_W'(1);
            if (in_exec && dec.late && cond_met)
                late_q <= 1'b1;
            if (in_exec && dec.bad)
                err_q <= 1'b1;
            if ((state_q == ST_WAIT) && !cond_met && expired) begin
                tmo_q <= 1'b1;
                irq_q <= irq_en;
            end
        end
    end

    // outputs
    always_comb begin
        wait_active = (in_exec && (dec.pause || dec.late)) || (state_q == ST_WAIT);
        wait_sel    = wait_active ? cmd_q[EVT_W-1:0] : '0;
        wait_or     = wait_active && cmd_q[BIT_OR];
        wait_inv    = wait_active && cmd_q[BIT_INV];
        upload_stb  = (in_exec && dec.upload) ? cmd_q[NSEC-1:0] : '0;
        sig_set     = (in_exec && dec.set)    ? cmd_q[NSIG-1:0] : '0;
        sig_clr     = (in_exec && dec.clr)    ? cmd_q[NSIG-1:0] : '0;
        busy        = (state_q != ST_IDLE);
        st_timeout  = tmo_q;
        st_late     = late_q;
        st_error    = err_q;
        irq         = irq_q;
    end
endmodule

// File: rtl/regprog_seq_chk.sv
module regprog_seq_chk #(
    parameter int AW   = 32,
    parameter int NSEC = 8,
    parameter int NSIG = 8
)(
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_rvalid,
    input logic            wait_active,
    input logic [25:0]     wait_sel,
    input logic [NSEC-1:0] upload_stb,
    input logic [NSIG-1:0] sig_set,
    input logic [NSIG-1:0] sig_clr,
    input logic            busy,
    input logic            st_timeout,
    input logic            st_late,
    input logic            st_error,
    input logic            irq
);
    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (mem_addr == $past(mem_addr) + AW'(4))); // R2
    AST_UPLOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upload_stb != '0) |=> (upload_stb == '0)); // R4
    AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((sig_set != '0) || (sig_clr != '0)) |-> busy); // R5
    AST_WAIT_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_active && $past(wait_active)) |-> $stable(wait_sel)); // R6
    AST_LATE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_late) |-> !wait_active); // R7
    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_timeout) |-> !busy); // R8
    AST_IRQ_NEEDS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_timeout); // R9
    AST_ERROR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_error) |-> !busy); // R12
endmodule

bind regprog_seq regprog_seq_chk #(.AW(AW), .NSEC(NSEC), .NSIG(NSIG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .wait_active (wait_active),
    .wait_sel    (wait_sel),
    .upload_stb  (upload_stb),
    .sig_set     (sig_set),
    .sig_clr     (sig_clr),
    .busy        (busy),
    .st_timeout  (st_timeout),
    .st_late     (st_late),
    .st_error    (st_error),
    .irq         (irq)
);

// File: tb/regprog_seq_bench.sv
module regprog_seq_bench;
    localparam int TW = 8;
    localparam logic [31:0] W_STOP = 32'h5000_0000;
    localparam logic [31:0] W_JUNK = 32'hF000_0000;
    localparam logic [31:0] W_TAIL = 32'h4000_00FF;

    typedef struct packed {
        logic [31:0] cmd;
        logic [3:0]  extra;
        logic        cond;
        logic [7:0]  up;
        logic [7:0]  set;
        logic [7:0]  clr;
        logic        late;
        logic        err;
        logic        tmo;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 4'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
        '{32'h0000_0003, 4'd0, 1'b0, 8'h00, 8'h00, 8'h03, 1'b0, 1'b0, 1'b0},
        '{32'h4000_0005, 4'd0, 1'b0, 8'h00, 8'h05, 8'h00, 1'b0, 1'b0, 1'b0},
        '{32'h2000_00A5, 4'd0, 1'b0, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
        '{32'h1C00_0ABC, 4'd0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
        '{32'h1000_0002, 4'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
        '{32'h3000_0004, 4'd0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},
        '{32'h3C00_0004, 4'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
        '{32'h7000_0000, 4'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},
        '{32'hF123_4567, 4'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},
        '{32'h6000_0002, 4'd2, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
        '{32'h5000_0000, 4'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   start_addr = '0;
    logic [TW-1:0] tmo_limit = '0;
    logic          tmo_count_clk = 1'b1;
    logic          tmo_count_vsync = 1'b0;
    logic          vsync = 1'b0;
    logic          irq_en = 1'b1;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic          mem_rvalid;
    logic [31:0]   mem_rdata;
    logic          wait_active;
    logic [25:0]   wait_sel;
    logic          wait_or, wait_inv;
    logic          cond_met = 1'b0;
    logic [7:0]    upload_stb, sig_set, sig_clr;
    logic          busy, st_timeout, st_late, st_error, irq;

    logic [31:0] img [16];
    logic [31:0] base = '0;
    logic [31:0] offs;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0]  up_acc, set_acc, clr_acc;
    int          wait_cyc, nfetch;
    logic [25:0] w_sel;
    logic        w_or, w_inv, seen_req;
    logic [31:0] first_addr;

    always #2 clk = ~clk;

    regprog_seq #(.TW(TW)) u_regprog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .tmo_limit(tmo_limit), .tmo_count_clk(tmo_count_clk),
        .tmo_count_vsync(tmo_count_vsync), .vsync(vsync), .irq_en(irq_en),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .wait_active(wait_active), .wait_sel(wait_sel),
        .wait_or(wait_or), .wait_inv(wait_inv), .cond_met(cond_met),
        .upload_stb(upload_stb), .sig_set(sig_set), .sig_clr(sig_clr),
        .busy(busy), .st_timeout(st_timeout), .st_late(st_late),
        .st_error(st_error), .irq(irq)
    );

    // memory responder: one cycle of latency
    assign offs      = mem_addr - base;
    assign mem_rdata = img[offs[5:2]];
    always @(posedge clk) begin
        if (!rst_n) mem_rvalid <= 1'b0;
        else        mem_rvalid <= mem_req && !mem_rvalid;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            $display("FAIL watchdog: act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic sample();
        up_acc  |= upload_stb;
        set_acc |= sig_set;
        clr_acc |= sig_clr;
        if (wait_active) begin
            wait_cyc++;
            w_sel = wait_sel;
            w_or  = wait_or;
            w_inv = wait_inv;
        end
        if (mem_rvalid) nfetch++;
        if (mem_req && !seen_req) begin
            seen_req   = 1'b1;
            first_addr = mem_addr;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            sample();
        end
    endtask

    task automatic load_img(input logic [31:0] cmd, input int extra);
        for (int i = 0; i < 16; i++) img[i] = W_JUNK;
        img[0] = cmd;
        img[extra + 1] = W_STOP;
        img[extra + 2] = W_TAIL;
    endtask

    task automatic kick(input logic [31:0] addr);
        up_acc = '0; set_acc = '0; clr_acc = '0;
        wait_cyc = 0; nfetch = 0; seen_req = 1'b0;
        w_sel = '0; w_or = 1'b0; w_inv = 1'b0; first_addr = '0;
        @(negedge clk);
        base = addr;
        start_addr = addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sample();
    endtask

    task automatic run_to_idle();
        int n = 0;
        while (busy && n < 400) begin
            @(negedge clk);
            sample();
            n++;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) img[i] = W_JUNK;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 strobes", {8'b0, upload_stb, sig_set, sig_clr}, 32'd0);
        chk("R1 status", {27'b0, wait_active, st_timeout, st_late, st_error, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {31'b0, busy}, 32'd0);

        // vector table
        tmo_limit = 8'd4;
        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            automatic int exp_f = (v.err || v.tmo || v.cmd[31:28] == 4'h5) ? 1 : int'(v.extra) + 2;
            load_img(v.cmd, int'(v.extra));
            cond_met = v.cond;
            kick(32'h0000_0100 + 32'(i * 64));
            run_to_idle();
            chk($sformatf("R2 v%0d first addr", i), first_addr, 32'h0000_0100 + 32'(i * 64));
            chk($sformatf("R3 R11 v%0d fetches", i), 32'(nfetch), 32'(exp_f));
            chk($sformatf("R4 v%0d upload", i), {24'b0, up_acc}, {24'b0, v.up});
            chk($sformatf("R5 v%0d set", i), {24'b0, set_acc}, {24'b0, v.set});
            chk($sformatf("R5 v%0d clr", i), {24'b0, clr_acc}, {24'b0, v.clr});
            chk($sformatf("R7 v%0d late", i), {31'b0, st_late}, {31'b0, v.late});
            chk($sformatf("R12 R13 v%0d error", i), {31'b0, st_error}, {31'b0, v.err});
            chk($sformatf("R8 v%0d timeout", i), {31'b0, st_timeout}, {31'b0, v.tmo});
            chk($sformatf("R9 v%0d irq", i), {31'b0, irq}, {31'b0, v.tmo});
            chk($sformatf("R11 v%0d busy", i), {31'b0, busy}, 32'd0);
            if (i == 4) begin
                chk("R6 wait_sel", {6'b0, w_sel}, 32'h0000_0ABC);
                chk("R6 wait_or/inv", {30'b0, w_or, w_inv}, 32'd3);
            end
        end

        // R8: exact stall length with clock counting
        tmo_limit = 8'd3;
        cond_met = 1'b0;
        load_img(32'h1000_0001, 0);
        kick(32'h0000_2000);
        run_to_idle();
        chk("R8 wait cycles", 32'(wait_cyc), 32'd5);
        chk("R8 later command skipped", {24'b0, set_acc}, 32'd0);

        // R8: vsync-only counting
        tmo_count_clk = 1'b0;
        tmo_count_vsync = 1'b1;
        tmo_limit = 8'd2;
        load_img(32'h1000_0001, 0);
        kick(32'h0000_2400);
        tick(60);
        chk("R8 clocks not counted", {31'b0, busy}, 32'd1);
        vsync = 1'b1; tick(1); vsync = 1'b0; tick(5);
        chk("R8 one vsync", {31'b0, busy}, 32'd1);
        vsync = 1'b1; tick(1); vsync = 1'b0;
        run_to_idle();
        chk("R8 vsync timeout", {31'b0, st_timeout}, 32'd1);

        // R10 and R2: zero limit, start while busy ignored
        tmo_count_clk = 1'b1;
        tmo_count_vsync = 1'b0;
        tmo_limit = 8'd0;
        for (int i = 0; i < 16; i++) img[i] = W_JUNK;
        img[0] = 32'h1000_0001;
        img[1] = 32'h4000_0001;
        img[2] = W_STOP;
        kick(32'h0000_3000);
        tick(300);
        chk("R10 still waiting", {31'b0, busy}, 32'd1);
        start_addr = 32'h0000_3008;
        start = 1'b1; tick(1); start = 1'b0;
        tick(3);
        cond_met = 1'b1;
        run_to_idle();
        chk("R2 start while busy ignored", {24'b0, set_acc}, 32'd1);
        chk("R10 no timeout", {31'b0, st_timeout}, 32'd0);

        // R9: interrupt disabled
        irq_en = 1'b0;
        tmo_limit = 8'd2;
        cond_met = 1'b0;
        load_img(32'h1000_0001, 0);
        kick(32'h0000_4000);
        run_to_idle();
        chk("R9 timeout set", {31'b0, st_timeout}, 32'd1);
        chk("R9 irq masked", {31'b0, irq}, 32'd0);

        // R13: status cleared by a new start
        irq_en = 1'b1;
        load_img(32'h0000_0000, 0);
        kick(32'h0000_5000);
        run_to_idle();
        chk("R13 timeout cleared", {31'b0, st_timeout}, 32'd0);
        chk("R5 NOP no strobes", {16'b0, set_acc, clr_acc}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule